// File: doc/BRIEF.md
# Multi-Pattern PRBS Generator

This block produces a pseudo-random binary sequence, one bit on every enabled clock edge, for driving test data into a high-speed path from inside the chip. A 2-bit select chooses one of four maximal-length sequences, with periods of 127, 32767, 8388607 and 2147483647 bits. All four are produced by one shared 31-stage shift register. The feedback is the XOR of two tap stages.

The select is folded into the register's next-state logic. Each pattern contributes one gated XOR term, and the terms are OR-ed into the first stage, so the loop is one XOR level plus a shallow AND-OR. No multiplexer stage sits behind the XOR. A change of select, or a reset, reloads an all-ones seed, so the active bits can never be all zero. A one-cycle flag marks each return of the active bits to the seed, which gives the period directly. With enable low, the state and the output bit hold.

Top module: `prbs_multi_gen`

## Requirements
- R1: The select value picks the polynomial as follows: 0 gives x^7+x^6+1, 1 gives x^15+x^14+1, 2 gives x^23+x^18+1 and 3 gives x^31+x^28+1. The active register is the low n stages, where n is the polynomial degree.
- R2: Stages are numbered 1 to 31. On each advancing edge, the feedback bit is stage n XOR stage m of the state before the edge, where x^m is the middle term. Every stage k takes stage k-1, stage 1 takes the feedback bit, and `prbs_out` takes the same feedback bit.
- R3: Synchronous active-low reset loads all ones into every stage, clears `prbs_out` and `period_pulse`, and captures the select.
- R4: On any non-reset edge where `pat_sel` differs from the select captured at the previous edge, the block reloads the all-ones seed, clears `prbs_out` and `period_pulse`, and captures the new select, whatever the state of `enable`.
- R5: With `enable` low and the select unchanged, the state and `prbs_out` hold and `period_pulse` is 0.
- R6: `period_pulse` is 1 for exactly the one cycle after an advance that brings the active bits back to all ones. From a seed load, this happens on advance number 2^n-1.
- R7: The active bits are never all zero.
- R8: No active state repeats within one period. For the 7-bit and 15-bit settings, `period_pulse` stays 0 on every advance before number 2^n-1.
- R9: The block is full-rate: every enabled edge with an unchanged select produces a new output bit, with no idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pat_sel | input | 2 | Pattern select, 0 to 3 |
| enable | input | 1 | Advance the sequence when high |
| prbs_out | output | 1 | Serial sequence bit |
| period_pulse | output | 1 | One-cycle pulse when the active bits return to the seed |

## Verification
The assertions check four things on every cycle: the active bits never become zero, a hold leaves the output bit untouched, a select change reloads the seed, and the period pulse is a lone one-cycle pulse that coincides with the seed state. The exact bit sequence for each polynomial, the period length, and the absence of repeated states can only be shown by the bench's scenarios. The bench runs a full 127-bit period and a full 32767-bit period and compares each bit against an independent model, while tracking which model states have already been visited.

// File: rtl/prbs_pkg.sv
// Package: shared constants and tap tables for the multi-pattern PRBS generator.
// Assumes every long tap is no greater than LFSR_W and the short tap is below the long tap.
package prbs_pkg;

    localparam int LFSR_W  = 31;
    localparam int NUM_PAT = 4;
    localparam int SEL_W   = $clog2(NUM_PAT);

    // Degree (long tap) of the polynomial for pattern p.
    function automatic int tap_long(input int p);
        case (p)
            0:       return 7;
            1:       return 15;
            2:       return 23;
            default: return 31;
        endcase
    endfunction

    // Middle-term tap of the polynomial for pattern p.
    function automatic int tap_short(input int p);
        case (p)
            0:       return 6;
            1:       return 14;
            2:       return 18;
            default: return 28;
        endcase
    endfunction

endpackage

// File: rtl/prbs_pattern_ctrl.sv
// Module: captures the pattern select, decodes it one-hot and decides each edge
// whether the register reseeds, advances or holds.
// Assumes pat_sel is synchronous to clk.
module prbs_pattern_ctrl
    import prbs_pkg::*;
#(
    parameter int NP = NUM_PAT,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] pat_sel,
    input  logic          enable,
    output logic [SW-1:0] sel_q,
    output logic [NP-1:0] sel_oh,
    output logic          load,
    output logic          adv
);

    // Capture the select on reset and on every change.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            sel_q <= pat_sel;
        end
    end

    // One-hot decode of the captured select.
    for (genvar p = 0; p < NP; p++) begin : g_dec
        localparam logic [SW-1:0] CODE = SW'(p);
        assign sel_oh[p] = (sel_q == CODE);
    end

    // A changed select reseeds and takes priority over advancing.
    assign load = (pat_sel != sel_q);
    assign adv  = enable & ~load;

endmodule

// File: rtl/prbs_lfsr_core.sv
// Module: the shared shift register. The feedback is an AND-OR of one gated tap XOR
// per pattern, so the select costs no multiplexer level behind the XOR.
// Assumes sel_oh is one-hot. Stages above the active degree shift along unused.
module prbs_lfsr_core
    import prbs_pkg::*;
#(
    parameter int W  = LFSR_W,
    parameter int NP = NUM_PAT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [NP-1:0] sel_oh,
    output logic [W-1:0]  state,
    output logic          fb
);

    logic [NP-1:0] term;
    logic [W-1:0]  nxt;

    // One gated tap XOR per pattern.
    for (genvar p = 0; p < NP; p++) begin : g_tap
        localparam int HI = tap_long(p);
        localparam int LO = tap_short(p);
        assign term[p] = sel_oh[p] & (state[HI-1] ^ state[LO-1]);
    end

    assign fb = |term;

    // Next-state input of each stage.
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign nxt[i] = fb;
        end else begin : g_rest
            assign nxt[i] = state[i-1];
        end
    end

    // Seed load, shift, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            state <= '1;
        end else if (adv) begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/prbs_period_mon.sv
// Module: registers the serial output bit and raises a one-cycle pulse when an
// advance brings the active bits back to all ones.
// Assumes sel_oh is one-hot and every pattern degree is at least 2.
module prbs_period_mon
    import prbs_pkg::*;
#(
    parameter int W  = LFSR_W,
    parameter int NP = NUM_PAT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [NP-1:0] sel_oh,
    input  logic [W-1:0]  state,
    input  logic          fb,
    output logic          dout,
    output logic          pulse
);

    logic [NP-1:0] wrap;

    // The next active value is all ones when the shifted-in bits are ones and fb is 1.
    for (genvar p = 0; p < NP; p++) begin : g_wrap
        localparam int HI = tap_long(p);
        assign wrap[p] = sel_oh[p] & fb & (&state[HI-2:0]);
    end

    // Output bit and period pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            dout  <= 1'b0;
            pulse <= 1'b0;
        end else if (adv) begin
            dout  <= fb;
            pulse <= |wrap;
        end else begin
            pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/prbs_multi_gen.sv
// Module: top of the multi-pattern PRBS generator. Produces one bit per enabled clock
// from a shared 31-stage register using one of four polynomials.
// Assumes a synchronous active-low reset and inputs synchronous to clk.
module prbs_multi_gen
    import prbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] pat_sel,
    input  logic             enable,
    output logic             prbs_out,
    output logic             period_pulse
);

    logic [SEL_W-1:0]   sel_q;
    logic [NUM_PAT-1:0] sel_oh;
    logic               load;
    logic               adv;
    logic [LFSR_W-1:0]  state;
    logic               fb;

    prbs_pattern_ctrl #(.NP(NUM_PAT), .SW(SEL_W)) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .pat_sel(pat_sel),
        .enable (enable),
        .sel_q  (sel_q),
        .sel_oh (sel_oh),
        .load   (load),
        .adv    (adv)
    );

    prbs_lfsr_core #(.W(LFSR_W), .NP(NUM_PAT)) i_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (adv),
        .sel_oh(sel_oh),
        .state (state),
        .fb    (fb)
    );

    prbs_period_mon #(.W(LFSR_W), .NP(NUM_PAT)) i_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (adv),
        .sel_oh(sel_oh),
        .state (state),
        .fb    (fb),
        .dout  (prbs_out),
        .pulse (period_pulse)
    );

endmodule

// File: rtl/prbs_multi_gen_chk.sv
// Module: assertion checker for prbs_multi_gen, bound to the top module.
// Assumes it sees the register state and the captured select of the top.
module prbs_multi_gen_chk
    import prbs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  pat_sel,
    input logic              enable,
    input logic              prbs_out,
    input logic              period_pulse,
    input logic [LFSR_W-1:0] state,
    input logic [SEL_W-1:0]  sel_q
);

    logic [LFSR_W-1:0] mask;

    // Active-bit mask for the captured select.
    always_comb begin
        case (sel_q)
            2'd0:    mask = LFSR_W'(32'h7F);
            2'd1:    mask = LFSR_W'(32'h7FFF);
            2'd2:    mask = LFSR_W'(32'h7FFFFF);
            default: mask = LFSR_W'(32'h7FFFFFFF);
        endcase
    end

    assert_no_lockup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state & mask) != '0);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && pat_sel == sel_q) |=> ($stable(prbs_out) && !period_pulse));

    assert_reseed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel != sel_q) |=> (!prbs_out && !period_pulse && (state & mask) == mask));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        period_pulse |=> !period_pulse);

    assert_pulse_at_seed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        period_pulse |-> ((state & mask) == mask));

    assert_out_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pat_sel == sel_q) |=> (state[0] == prbs_out));

endmodule

bind prbs_multi_gen prbs_multi_gen_chk i_prbs_multi_gen_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pat_sel     (pat_sel),
    .enable      (enable),
    .prbs_out    (prbs_out),
    .period_pulse(period_pulse),
    .state       (state),
    .sel_q       (sel_q)
);

// File: tb/test_prbs_multi_gen.sv
// Bench: drives prbs_multi_gen with directed and seeded random stimulus and compares
// every output bit and pulse against an independent polynomial model.
module test_prbs_multi_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] pat_sel;
    logic       enable;
    logic       prbs_out;
    logic       period_pulse;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    logic [30:0] m_st;
    logic [1:0]  m_sel;
    logic        m_out;
    logic        m_pulse;
    bit          seen [0:32767];

    prbs_multi_gen i_prbs_multi_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .pat_sel     (pat_sel),
        .enable      (enable),
        .prbs_out    (prbs_out),
        .period_pulse(period_pulse)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    function automatic int deg(input logic [1:0] s);
        case (s)
            2'd0: return 7;
            2'd1: return 15;
            2'd2: return 23;
            default: return 31;
        endcase
    endfunction

    function automatic int mid(input logic [1:0] s);
        case (s)
            2'd0: return 6;
            2'd1: return 14;
            2'd2: return 18;
            default: return 28;
        endcase
    endfunction

    function automatic logic [30:0] amask(input logic [1:0] s);
        return 31'h7FFF_FFFF >> (31 - deg(s));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update the model, check at the next falling edge.
    task automatic tick(input logic rs, input logic en, input logic [1:0] s, input string req);
        logic fbit;
        rst_n   = rs;
        enable  = en;
        pat_sel = s;
        if (!rs || s != m_sel) begin
            m_st = '1; m_sel = s; m_out = 1'b0; m_pulse = 1'b0;
        end else if (en) begin
            fbit    = m_st[deg(m_sel)-1] ^ m_st[mid(m_sel)-1];
            m_st    = {m_st[29:0], fbit};
            m_out   = fbit;
            m_pulse = ((m_st & amask(m_sel)) == amask(m_sel));
        end else begin
            m_pulse = 1'b0;
        end
        @(negedge clk);
        chk(prbs_out == m_out, {req, " out"}, int'(prbs_out), int'(m_out));
        chk(period_pulse == m_pulse, {req, " pulse"}, int'(period_pulse), int'(m_pulse));
    endtask

    // Full-period run from a fresh seed: the pulse must appear only on the last advance.
    task automatic full_period(input logic [1:0] s);
        int n = (1 << deg(s)) - 1;
        int rep = 0;
        foreach (seen[k]) seen[k] = 1'b0;
        for (int k = 1; k <= n; k++) begin
            tick(1'b1, 1'b1, s, "R2 R9 sequence");
            if (seen[int'(m_st[14:0] & amask(s)[14:0])]) rep++;
            seen[int'(m_st[14:0] & amask(s)[14:0])] = 1'b1;
            if (k < n) chk(period_pulse == 1'b0, "R8 early pulse", int'(period_pulse), 0);
        end
        chk(period_pulse == 1'b1, "R6 period end", int'(period_pulse), 1);
        chk(rep == 0, "R8 repeated model state", rep, 0);
        tick(1'b1, 1'b1, s, "R6 after period");
        chk(period_pulse == 1'b0, "R6 single cycle", int'(period_pulse), 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] rs_sel;
        logic       hold_out;
        void'($urandom(32'd20210529));
        m_st = '1; m_sel = 2'd0; m_out = 1'b0; m_pulse = 1'b0;
        rst_n = 1'b0; enable = 1'b0; pat_sel = 2'd0;
        @(negedge clk);

        // R3: reset state.
        repeat (3) tick(1'b0, 1'b1, 2'd0, "R3 reset");
        chk(prbs_out == 1'b0 && period_pulse == 1'b0, "R3 reset outputs", int'(prbs_out), 0);

        // R1 R8: full 127-bit period.
        full_period(2'd0);

        // R5: hold with enable low.
        hold_out = prbs_out;
        repeat (6) begin
            tick(1'b1, 1'b0, 2'd0, "R5 hold");
            chk(prbs_out == hold_out, "R5 held bit", int'(prbs_out), int'(hold_out));
        end
        repeat (10) tick(1'b1, 1'b1, 2'd0, "R5 resume");

        // R4: select change reseeds, then full 32767-bit period.
        tick(1'b1, 1'b1, 2'd1, "R4 reseed");
        chk(prbs_out == 1'b0, "R4 reseed clears out", int'(prbs_out), 0);
        full_period(2'd1);

        // R1: 23-bit and 31-bit settings, partial runs.
        tick(1'b1, 1'b1, 2'd2, "R4 reseed 23");
        repeat (400) tick(1'b1, 1'b1, 2'd2, "R1 pattern 23");
        tick(1'b1, 1'b0, 2'd3, "R4 reseed while idle");
        chk(prbs_out == 1'b0, "R4 reseed with enable low", int'(prbs_out), 0);
        repeat (400) tick(1'b1, 1'b1, 2'd3, "R1 pattern 31");

        // R3: reset in mid-run.
        tick(1'b0, 1'b1, 2'd3, "R3 mid reset");
        chk(prbs_out == 1'b0, "R3 mid reset out", int'(prbs_out), 0);
        repeat (50) tick(1'b1, 1'b1, 2'd3, "R7 after reset");

        // Seeded random mix of enable, select changes and rare resets.
        rs_sel = 2'd0;
        for (int k = 0; k < 6000; k++) begin
            if (($urandom % 50) == 0) rs_sel = 2'($urandom % 4);
            tick(($urandom % 400) != 0, ($urandom % 5) != 0, rs_sel, "R2 R4 R5 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule